// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block keeps the interrupt status, controller status and two system configuration registers of a NAND-style flash controller. It sits between a 16-bit register bus and a separate command engine. Software writes command codes, configuration and interrupt acknowledgements over the bus. The command engine reports each finished operation and each failure back through single-cycle pulses. The block decides whether a command write is taken, hands accepted codes to the engine, and drives the interrupt and ready pins.

The interrupt status register has one master flag and four completion flags. The controller status register holds four sticky error flags. Software acknowledges interrupts by writing an AND-mask to the interrupt register. Once that mask drops the master flag, all error flags are cleared as well. While the master flag is pending, command writes are dropped. This keeps a new command from overrunning an unacknowledged result. The two reset command codes are handled inside the block: they restore the register defaults without involving the engine.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the registers read as follows: configuration-1 reads 0x40C0, configuration-2 reads 0, status reads 0, interrupt status reads 0x8080 and command reads 0. `rdy_o` is 1 and `cmd_valid_o` is 0.
- R2: A pulse on `done_i[k]` sets interrupt bit 4+k and the master bit 15 at the next edge. The index k is 0 for reset, 1 for erase, 2 for program and 3 for load.
- R3: A pulse on `err_i[k]` sets status bit 10+k at the next edge. The index k is 0 for command, 1 for erase, 2 for program and 3 for load. These bits stay set until they are cleared.
- R4: A write to the interrupt register (address 4) replaces the interrupt status with its AND with the written value. If bit 15 of that result is 0, status bits 10 to 13 are cleared.
- R5: Completion and error pulses that arrive in the same cycle as an interrupt-register write are ORed in after the mask and the clear are applied.
- R6: A write to the command register (address 0) while interrupt bit 15 is set has no effect. `cmd_valid_o` stays 0 and the command register keeps its value.
- R7: An accepted, recognised, non-reset command code is stored. The cycle after the write, `cmd_valid_o` is 1 for one cycle and `cmd_o` carries the code. The recognised codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0x65, 0xF0 and 0xF3.
- R8: An accepted, unrecognised command code is stored but not issued. It sets status bit 10 and interrupt bit 15.
- R9: An accepted command 0xF0 or 0xF3 is a warm reset and is not issued. Configuration-1, configuration-2, status and `rdy_o` return to their R1 values, command reads 0 and interrupt status reads 0x8010.
- R10: `irq_o` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6, with no added latency. When bit 6 is 1 the interrupt is active high; when it is 0 it is active low.
- R11: A write to configuration-1 (address 1) sets `rdy_o` to bit 7 of the written value at the next edge.
- R12: Configuration-1 reads back with bits 4:0 forced to 0. Configuration-2 (address 2) reads back exactly as written.
- R13: Status (address 3) is read-only, and writes to it are ignored. Reads from addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| done_i | input | 4 | Completion pulses: reset, erase, program, load |
| err_i | input | 4 | Error pulses: command, erase, program, load |
| cmd_o | output | 16 | Last accepted command code |
| cmd_valid_o | output | 1 | One-cycle pulse when a command is issued |
| irq_o | output | 1 | Interrupt pin level |
| rdy_o | output | 1 | Ready pin level |

## Verification
An interrupt acknowledgement write and incoming engine pulses can fall in the same cycle. The bench provokes this directly, with a clearing mask together with an erase done pulse and an erase error pulse. It then expects the fresh flags to survive the clear. The bench also hits this collision repeatedly in random traffic, where sparse pulses overlap bus writes. A second collision arises when a command write meets a pending master flag. A reference model in the bench judges every cycle of both collisions: it predicts the register file, the pins and the issue pulse.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DATA_W       = 16;
  localparam int EV_N         = 4;
  localparam int INT_MASTER   = 15;
  localparam int INT_DONE_LSB = 4;
  localparam int ERR_LSB      = 10;
  localparam int CFG_POL_BIT  = 6;
  localparam int CFG_RDY_BIT  = 7;
  localparam int CFG_RO_BITS  = 5;

  localparam logic [DATA_W-1:0] CFG1_RST = 16'h40C0;
  localparam logic [DATA_W-1:0] INT_COLD = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM = 16'h8010;

  localparam int REG_CMD  = 0;
  localparam int REG_CFG1 = 1;
  localparam int REG_CFG2 = 2;
  localparam int REG_STAT = 3;
  localparam int REG_INT  = 4;

  function automatic logic cmd_is_reset(input logic [DATA_W-1:0] c);
    return (c == 16'h00F0) || (c == 16'h00F3);
  endfunction

  function automatic logic cmd_known(input logic [DATA_W-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065,
      16'h00F0, 16'h00F3: return 1'b1;
      default:            return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fic_cmd_gate.sv
module fic_cmd_gate
  import fic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              int_master_i,
  output logic              warm_rst_o,
  output logic              unknown_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_q_o
);
  logic accept;

  // pending master interrupt blocks new commands
  assign accept     = wr_cmd_i & ~int_master_i;
  assign warm_rst_o = accept & cmd_is_reset(wdata_i);
  assign unknown_o  = accept & ~cmd_known(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q_o     <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= accept & cmd_known(wdata_i) & ~cmd_is_reset(wdata_i);
      if (warm_rst_o)  cmd_q_o <= '0;
      else if (accept) cmd_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/fic_irq_regs.sv
module fic_irq_regs
  import fic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_int_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [EV_N-1:0]   done_i,
  input  logic [EV_N-1:0]   err_i,
  input  logic              unknown_i,
  input  logic              warm_rst_i,
  output logic [DATA_W-1:0] int_q_o,
  output logic [DATA_W-1:0] stat_q_o
);
  logic [DATA_W-1:0] ev_int, ev_stat, masked, int_n, stat_n;

  for (genvar b = 0; b < DATA_W; b++) begin : g_ev
    if (b >= INT_DONE_LSB && b < INT_DONE_LSB + EV_N) begin : g_done
      assign ev_int[b] = done_i[b-INT_DONE_LSB];
    end else begin : g_nodone
      assign ev_int[b] = 1'b0;
    end
    if (b >= ERR_LSB && b < ERR_LSB + EV_N) begin : g_err
      assign ev_stat[b] = err_i[b-ERR_LSB];
    end else begin : g_noerr
      assign ev_stat[b] = 1'b0;
    end
  end

  always_comb begin
    masked = wr_int_i ? (int_q_o & wdata_i) : int_q_o;
    stat_n = stat_q_o;
    if (wr_int_i && !masked[INT_MASTER]) stat_n[ERR_LSB +: EV_N] = '0;
    // new events land after the acknowledge mask
    int_n  = masked | ev_int;
    stat_n = stat_n | ev_stat;
    if (|done_i) int_n[INT_MASTER] = 1'b1;
    if (unknown_i) begin
      int_n[INT_MASTER] = 1'b1;
      stat_n[ERR_LSB]   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q_o  <= INT_COLD;
      stat_q_o <= '0;
    end else if (warm_rst_i) begin
      int_q_o  <= INT_WARM;
      stat_q_o <= '0;
    end else begin
      int_q_o  <= int_n;
      stat_q_o <= stat_n;
    end
  end
endmodule

// File: rtl/fic_cfg_regs.sv
module fic_cfg_regs
  import fic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cfg1_i,
  input  logic              wr_cfg2_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              warm_rst_i,
  output logic [DATA_W-1:0] cfg1_q_o,
  output logic [DATA_W-1:0] cfg2_q_o,
  output logic              rdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q_o <= CFG1_RST;
      cfg2_q_o <= '0;
      rdy_o    <= 1'b1;
    end else if (warm_rst_i) begin
      cfg1_q_o <= CFG1_RST;
      cfg2_q_o <= '0;
      rdy_o    <= 1'b1;
    end else begin
      if (wr_cfg1_i) begin
        cfg1_q_o <= wdata_i;
        rdy_o    <= wdata_i[CFG_RDY_BIT];
      end
      if (wr_cfg2_i) cfg2_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import fic_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EV_N-1:0]   done_i,
  input  logic [EV_N-1:0]   err_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_valid_o,
  output logic              irq_o,
  output logic              rdy_o
);
  localparam logic [DATA_W-1:0] CFG1_RD_MASK = ~DATA_W'((1 << CFG_RO_BITS) - 1);

  logic              wr_cmd, wr_cfg1, wr_cfg2, wr_int;
  logic              warm_rst, unknown;
  logic [DATA_W-1:0] int_q, stat_q, cfg1_q, cfg2_q;

  assign wr_cmd  = wr_en_i && (addr_i == AW'(REG_CMD));
  assign wr_cfg1 = wr_en_i && (addr_i == AW'(REG_CFG1));
  assign wr_cfg2 = wr_en_i && (addr_i == AW'(REG_CFG2));
  assign wr_int  = wr_en_i && (addr_i == AW'(REG_INT));

  fic_cmd_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_cmd_i     (wr_cmd),
    .wdata_i      (wdata_i),
    .int_master_i (int_q[INT_MASTER]),
    .warm_rst_o   (warm_rst),
    .unknown_o    (unknown),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_q_o      (cmd_o)
  );

  fic_irq_regs u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_int_i   (wr_int),
    .wdata_i    (wdata_i),
    .done_i     (done_i),
    .err_i      (err_i),
    .unknown_i  (unknown),
    .warm_rst_i (warm_rst),
    .int_q_o    (int_q),
    .stat_q_o   (stat_q)
  );

  fic_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cfg1_i  (wr_cfg1),
    .wr_cfg2_i  (wr_cfg2),
    .wdata_i    (wdata_i),
    .warm_rst_i (warm_rst),
    .cfg1_q_o   (cfg1_q),
    .cfg2_q_o   (cfg2_q),
    .rdy_o      (rdy_o)
  );

  // polarity bit set: active high
  assign irq_o = int_q[INT_MASTER] ^ ~cfg1_q[CFG_POL_BIT];

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(REG_CMD))  rdata_o = cmd_o;
    else if (addr_i == AW'(REG_CFG1)) rdata_o = cfg1_q & CFG1_RD_MASK;
    else if (addr_i == AW'(REG_CFG2)) rdata_o = cfg2_q;
    else if (addr_i == AW'(REG_STAT)) rdata_o = stat_q;
    else if (addr_i == AW'(REG_INT))  rdata_o = int_q;
  end
endmodule

// File: rtl/fic_checker.sv
module fic_checker
  import fic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_cmd,
  input logic              wr_cfg1,
  input logic              wr_int,
  input logic [DATA_W-1:0] wdata_i,
  input logic [EV_N-1:0]   done_i,
  input logic [EV_N-1:0]   err_i,
  input logic [DATA_W-1:0] int_q,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] cfg1_q,
  input logic              cmd_valid_o,
  input logic              irq_o,
  input logic              rdy_o
);
  p_done_master_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != '0) |=> int_q[INT_MASTER]);

  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != '0 && !wr_cmd) |=>
      ((stat_q[ERR_LSB +: EV_N] & $past(err_i)) == $past(err_i)));

  p_ack_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_int && !(int_q[INT_MASTER] && wdata_i[INT_MASTER]) && err_i == '0)
      |=> (stat_q[ERR_LSB +: EV_N] == '0));

  p_cmd_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && int_q[INT_MASTER]) |=> !cmd_valid_o);

  p_irq_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (int_q[INT_MASTER] == cfg1_q[CFG_POL_BIT]));

  p_rdy_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg1 |=> (rdy_o == $past(wdata_i[CFG_RDY_BIT])));
endmodule

bind flash_irq_ctrl fic_checker u_fic_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_cmd      (wr_cmd),
  .wr_cfg1     (wr_cfg1),
  .wr_int      (wr_int),
  .wdata_i     (wdata_i),
  .done_i      (done_i),
  .err_i       (err_i),
  .int_q       (int_q),
  .stat_q      (stat_q),
  .cfg1_q      (cfg1_q),
  .cmd_valid_o (cmd_valid_o),
  .irq_o       (irq_o),
  .rdy_o       (rdy_o)
);

// File: tb/test_flash_irq_ctrl.sv
`timescale 1ns/100ps
module test_flash_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  done_i = '0;
  logic [3:0]  err_i = '0;
  logic [15:0] cmd_o;
  logic        cmd_valid_o, irq_o, rdy_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference model
  logic [15:0] m_cfg1, m_cfg2, m_stat, m_int, m_cmd, m_vcmd;
  logic        m_rdy, m_valid;

  always #2.5 clk_i = ~clk_i;

  flash_irq_ctrl i_flash_irq_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .done_i, .err_i, .cmd_o, .cmd_valid_o, .irq_o, .rdy_o
  );

  function automatic bit known(input logic [15:0] c);
    logic [15:0] lst [17] = '{16'h00, 16'h13, 16'h80, 16'h1A, 16'h1B, 16'h23,
      16'h27, 16'h2A, 16'h2C, 16'h71, 16'h94, 16'h95, 16'hB0, 16'h30,
      16'h65, 16'hF0, 16'hF3};
    foreach (lst[i]) if (lst[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input bit cold);
    m_cfg1 = 16'h40C0; m_cfg2 = 0; m_stat = 0; m_cmd = 0; m_rdy = 1'b1;
    m_int = cold ? 16'h8080 : 16'h8010;
  endtask

  task automatic model_step(input bit we, input logic [2:0] a, input logic [15:0] w,
                            input logic [3:0] d, input logic [3:0] e);
    logic [15:0] ni, ns;
    bit acc;
    m_valid = 1'b0;
    acc = we && a == 3'd0 && !m_int[15];
    if (acc && (w == 16'hF0 || w == 16'hF3)) begin
      model_reset(1'b0);
      return;
    end
    ni = m_int; ns = m_stat;
    if (we && a == 3'd4) begin
      ni = m_int & w;
      if (!ni[15]) ns[13:10] = 4'b0;
    end
    if (we && a == 3'd1) begin m_cfg1 = w; m_rdy = w[7]; end
    if (we && a == 3'd2) m_cfg2 = w;
    if (acc) begin
      m_cmd = w;
      if (known(w)) begin m_valid = 1'b1; m_vcmd = w; end
      else begin ns[10] = 1'b1; ni[15] = 1'b1; end
    end
    for (int k = 0; k < 4; k++) begin
      if (d[k]) begin ni[4+k] = 1'b1; ni[15] = 1'b1; end
      if (e[k]) ns[10+k] = 1'b1;
    end
    m_int = ni; m_stat = ns;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr_i = a;
    #0.2;
    v = rdata_o;
  endtask

  task automatic check_all();
    logic [15:0] v;
    check("R7 valid", {15'b0, cmd_valid_o}, {15'b0, m_valid});
    if (m_valid) check("R7 code", cmd_o, m_vcmd);
    check("R10 irq", {15'b0, irq_o}, {15'b0, m_int[15] ^ ~m_cfg1[6]});
    check("R11 rdy", {15'b0, rdy_o}, {15'b0, m_rdy});
    rd(3'd0, v); check("R6 cmd reg", v, m_cmd);
    rd(3'd1, v); check("R12 cfg1", v, m_cfg1 & 16'hFFE0);
    rd(3'd2, v); check("R12 cfg2", v, m_cfg2);
    rd(3'd3, v); check("R3 status", v, m_stat);
    rd(3'd4, v); check("R2 intstat", v, m_int);
    rd(3'd5, v); check("R13 hole", v, 16'h0);
  endtask

  // called at a negedge; returns at the following negedge after checks
  task automatic step(input bit we, input logic [2:0] a, input logic [15:0] w,
                      input logic [3:0] d, input logic [3:0] e);
    wr_en_i = we; addr_i = a; wdata_i = w; done_i = d; err_i = e;
    @(posedge clk_i);
    model_step(we, a, w, d, e);
    @(negedge clk_i);
    wr_en_i = 1'b0; done_i = '0; err_i = '0;
    check_all();
  endtask

  task automatic peek(input logic [2:0] a, input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lst [17] = '{16'h00, 16'h13, 16'h80, 16'h1A, 16'h1B, 16'h23,
      16'h27, 16'h2A, 16'h2C, 16'h71, 16'h94, 16'h95, 16'hB0, 16'h30,
      16'h65, 16'hF0, 16'hF3};
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    model_reset(1'b1);
    m_valid = 1'b0; m_vcmd = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check_all();
    peek(3'd1, "R1 cfg1", 16'h40C0);
    peek(3'd4, "R1 int", 16'h8080);
    check("R1 rdy", {15'b0, rdy_o}, 16'h1);

    // R6 command blocked while master pending
    step(1, 3'd0, 16'h0094, 0, 0);
    check("R6 no issue", {15'b0, cmd_valid_o}, 16'h0);
    peek(3'd0, "R6 cmd kept", 16'h0000);

    // R3 then R4 acknowledge clears errors
    step(0, 3'd0, 0, 4'b0000, 4'b0101);
    peek(3'd3, "R3 err set", 16'h1400);
    step(1, 3'd4, 16'h00FF, 0, 0);
    peek(3'd4, "R4 and mask", 16'h0080);
    peek(3'd3, "R4 err clear", 16'h0000);

    // R7 accepted command issued
    step(1, 3'd0, 16'h0094, 0, 0);
    check("R7 issue", {15'b0, cmd_valid_o}, 16'h1);
    check("R7 cmd_o", cmd_o, 16'h0094);

    // R5 ack and events in one cycle
    step(1, 3'd4, 16'h0000, 4'b0010, 4'b0010);
    peek(3'd4, "R5 int after", 16'h8020);
    peek(3'd3, "R5 stat after", 16'h0800);

    // R8 unknown command
    step(1, 3'd4, 16'h0000, 0, 0);
    step(1, 3'd0, 16'h0055, 0, 0);
    check("R8 no issue", {15'b0, cmd_valid_o}, 16'h0);
    peek(3'd3, "R8 stat", 16'h0400);
    peek(3'd4, "R8 int", 16'h8000);

    // R10 polarity, R11 ready
    step(1, 3'd1, 16'h0000, 0, 0);
    check("R10 low-active pending", {15'b0, irq_o}, 16'h0);
    check("R11 rdy low", {15'b0, rdy_o}, 16'h0);
    step(1, 3'd4, 16'h0000, 0, 0);
    check("R10 low-active idle", {15'b0, irq_o}, 16'h1);

    // R12 readback, R13 status read-only
    step(1, 3'd1, 16'hFFFF, 0, 0);
    peek(3'd1, "R12 cfg1 mask", 16'hFFE0);
    step(1, 3'd2, 16'hA5A5, 0, 0);
    peek(3'd2, "R12 cfg2", 16'hA5A5);
    step(1, 3'd3, 16'hFFFF, 0, 0);
    peek(3'd3, "R13 stat ro", 16'h0000);

    // R9 warm reset by command
    step(0, 3'd0, 0, 0, 4'b1000);
    step(1, 3'd0, 16'h00F3, 0, 0);
    check("R9 no issue", {15'b0, cmd_valid_o}, 16'h0);
    peek(3'd4, "R9 int", 16'h8010);
    peek(3'd1, "R9 cfg1", 16'h40C0);
    peek(3'd2, "R9 cfg2", 16'h0000);
    peek(3'd3, "R9 stat", 16'h0000);
    peek(3'd0, "R9 cmd", 16'h0000);

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [2:0]  a;
      logic [15:0] w;
      logic [3:0]  d, e;
      bit          we;
      we = ($urandom % 4) != 0;
      a  = 3'($urandom % 6);
      w  = 16'($urandom);
      if (a == 3'd0) begin
        if ($urandom % 8 == 0) w = {8'h0, 8'($urandom)};
        else w = lst[$urandom % 15];
        if ($urandom % 40 == 0) w = lst[15 + $urandom % 2];
      end
      if (a == 3'd4 && ($urandom % 2)) w[15] = 1'b0;
      d = ($urandom % 5 == 0) ? 4'($urandom) : 4'b0;
      e = ($urandom % 6 == 0) ? 4'($urandom) : 4'b0;
      step(we, a, w, d, e);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule